// File: doc/BRIEF.md
# Redundant Control Word Recovery

This block sits on the receiving side of a serial video link, after bit alignment and word framing. Every 20-bit word comes with a kind tag that says whether it carries video, control or a phase-change marker. From a control word the block recovers nine control signals. The first five signals are each sent as three identical copies, and each is rebuilt by a two-out-of-three vote. The remaining four are single copies and are taken as received. From a video word it captures the 18 symbol bits without decoding them.

A small phase machine follows the kind of the last accepted word. The control outputs keep their value through video and transition words. The video outputs keep their value through control and transition words. A one-cycle flag reports each control word in which some triple did not agree, which means a bit error was voted away. Downstream logic, such as sync generation, can use the control outputs directly and can count the flag pulses as a measure of link quality.

Top module: `ctlword_rx`

Word layout, with bit 0 arriving first on the line. In a control word, bit 0 is an encoding bit that this block ignores. Bits 1..15 hold five triples: signal k uses bits 3k+1, 3k+2 and 3k+3 for k = 0..4. Bits 16..19 hold signals 5..8, one bit each. In a video word, bits 0 and 1 are encoding bits, and bits 2..19 are the 18 symbols in ascending order.

Kind codes on `word_kind_i`: 0 = video, 1 = control, 2 = transition, 3 = reserved, which is handled like a transition.

States of the phase machine: IDLE, CONTROL, VIDEO and TRANSITION. On `phase_o` these are reported as 0, 1, 2 and 3.
- IDLE is entered only by reset.
- Any state moves to CONTROL on an accepted control word.
- Any state moves to VIDEO on an accepted video word.
- Any state moves to TRANSITION on an accepted word of kind 2 or 3.
- With `word_valid_i` low, the machine stays in its current state.

## Requirements
- R1: While and after reset, and until the first accepted word, `ctrl_o`, `video_o`, `fix_o` and `phase_o` are all zero.
- R2: An accepted control word sets each of `ctrl_o[4:0]` to the value held by at least two of its three copies (bits 3k+1..3k+3). The update is visible one clock edge after acceptance. Bit 0 of the word has no effect.
- R3: An accepted control word copies word bits 16..19 unchanged to `ctrl_o[8:5]`.
- R4: `fix_o` is high for exactly the one cycle after an accepted control word in which at least one triple is not unanimous. It is low in every other cycle.
- R5: An accepted video word (kind 0) loads word bits 19..2 into `video_o[17:0]` one edge later and leaves `ctrl_o` unchanged.
- R6: Control words and transition words leave `video_o` unchanged.
- R7: A transition word (kind 2) or a reserved word (kind 3) leaves `ctrl_o` and `video_o` unchanged.
- R8: With `word_valid_i` low, none of the outputs change and `fix_o` is low, whatever appears on `word_i` and `word_kind_i`.
- R9: One edge after an accepted word, `phase_o` shows the state that word selects: 1 for control, 2 for video, 3 for kind 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| word_valid_i | input | 1 | A word is presented this cycle |
| word_kind_i | input | 2 | Word kind: 0 video, 1 control, 2 transition, 3 reserved |
| word_i | input | 20 | Framed 20-bit word, bit 0 first on the line |
| ctrl_o | output | 9 | Recovered control signals, held between control words |
| video_o | output | 18 | Captured video symbols, held between video words |
| fix_o | output | 1 | One-cycle pulse: the last control word had a split triple |
| phase_o | output | 2 | Phase machine state: 0 idle, 1 control, 2 video, 3 transition |

## Verification
Every result comes from a single register stage, so each output is due on the first rising edge after the word is presented. `fix_o` falls again on the edge after that unless another split control word follows. The bench changes inputs on falling edges and holds each word for one full cycle. It then reads all outputs on the next falling edge, half a cycle after the update. A further idle cycle and a second read confirm that the flag has dropped and that the held values stay in place.

// File: rtl/ctlword_rx_pkg.sv
package ctlword_rx_pkg;

    typedef enum logic [1:0] {
        KIND_VIDEO = 2'd0,
        KIND_CTRL  = 2'd1,
        KIND_TRANS = 2'd2,
        KIND_RSVD  = 2'd3
    } word_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CTRL  = 2'd1,
        PH_VIDEO = 2'd2,
        PH_TRANS = 2'd3
    } link_phase_e;

endpackage

// File: rtl/ctlword_vote3.sv
module ctlword_vote3 (
    input  logic [2:0] copies_i,
    output logic       bit_o,
    output logic       split_o
);
    always_comb begin
        bit_o   = (copies_i[0] & copies_i[1]) | (copies_i[0] & copies_i[2])
                | (copies_i[1] & copies_i[2]);
        split_o = (copies_i != 3'b000) && (copies_i != 3'b111);
    end

    // R2
    always_comb begin
        if (!split_o) begin
            unanimous_vote_chk: assert (copies_i == {3{bit_o}});
        end
    end
endmodule

// File: rtl/ctlword_phase_fsm.sv
module ctlword_phase_fsm
    import ctlword_rx_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        valid_i,
    input  word_kind_e  kind_i,
    output link_phase_e phase_o,
    output logic        ld_ctrl_o,
    output logic        ld_video_o
);
    link_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            unique case (kind_i)
                KIND_CTRL:  state_d = PH_CTRL;
                KIND_VIDEO: state_d = PH_VIDEO;
                KIND_TRANS: state_d = PH_TRANS;
                KIND_RSVD:  state_d = PH_TRANS;
                default:    state_d = PH_TRANS;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= PH_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        phase_o    = state_q;
        ld_ctrl_o  = valid_i && (kind_i == KIND_CTRL);
        ld_video_o = valid_i && (kind_i == KIND_VIDEO);
    end

    // R9
    video_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && kind_i == KIND_VIDEO) |=> (phase_o == PH_VIDEO));

    // R8
    idle_hold_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(phase_o));
endmodule

// File: rtl/ctlword_rx.sv
module ctlword_rx
    import ctlword_rx_pkg::*;
#(
    parameter int NUM_VOTED = 5,
    parameter int NUM_PLAIN = 4
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 word_valid_i,
    input  logic [1:0]                           word_kind_i,
    input  logic [3*NUM_VOTED+NUM_PLAIN:0]       word_i,
    output logic [NUM_VOTED+NUM_PLAIN-1:0]       ctrl_o,
    output logic [3*NUM_VOTED+NUM_PLAIN-2:0]     video_o,
    output logic                                 fix_o,
    output logic [1:0]                           phase_o
);
    localparam int WORD_W    = 3*NUM_VOTED + NUM_PLAIN + 1;
    localparam int CTRL_W    = NUM_VOTED + NUM_PLAIN;
    localparam int VID_W     = WORD_W - 2;
    localparam int PLAIN_LSB = 1 + 3*NUM_VOTED;

    word_kind_e  kind;
    link_phase_e phase;
    logic        ld_ctrl, ld_video;
    logic [NUM_VOTED-1:0] voted, split;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [VID_W-1:0]     video_q;
    logic                 fix_q;
    logic                 unused_enc_bit;

    assign kind           = word_kind_e'(word_kind_i);
    assign unused_enc_bit = word_i[0];

    ctlword_phase_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .valid_i    (word_valid_i),
        .kind_i     (kind),
        .phase_o    (phase),
        .ld_ctrl_o  (ld_ctrl),
        .ld_video_o (ld_video)
    );

    for (genvar g = 0; g < NUM_VOTED; g++) begin : g_vote
        ctlword_vote3 u_vote (
            .copies_i (word_i[1 + 3*g +: 3]),
            .bit_o    (voted[g]),
            .split_o  (split[g])
        );
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q  <= '0;
            video_q <= '0;
            fix_q   <= 1'b0;
        end else begin
            fix_q <= ld_ctrl && (|split);
            if (ld_ctrl)  ctrl_q  <= {word_i[PLAIN_LSB +: NUM_PLAIN], voted};
            if (ld_video) video_q <= word_i[WORD_W-1:2];
        end
    end

    assign ctrl_o  = ctrl_q;
    assign video_o = video_q;
    assign fix_o   = fix_q;
    assign phase_o = phase;

    // R4
    fix_after_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fix_o |-> $past(word_valid_i && word_kind_i == 2'd1));

    // R7
    ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(word_valid_i && word_kind_i == 2'd1) |=> $stable(ctrl_o));

    // R6
    video_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(word_valid_i && word_kind_i == 2'd0) |=> $stable(video_o));

    // R8
    idle_no_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_valid_i |=> !fix_o);
endmodule

// File: tb/ctlword_rx_bench.sv
module ctlword_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [19:0] word = '0;
    logic [8:0]  ctrl;
    logic [17:0] video;
    logic        fix;
    logic [1:0]  phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctlword_rx u_ctlword_rx (
        .clk_i(clk), .rst_ni(rst_n), .word_valid_i(valid), .word_kind_i(kind),
        .word_i(word), .ctrl_o(ctrl), .video_o(video), .fix_o(fix), .phase_o(phase)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] ctrl_word(input logic [8:0] c);
        logic [19:0] w = '0;
        for (int i = 0; i < 5; i++) w[1+3*i +: 3] = {3{c[i]}};
        w[19:16] = c[8:5];
        return w;
    endfunction

    // present one word for one cycle, then read outputs on the next falling edge
    task automatic send(input logic [1:0] k, input logic [19:0] w);
        @(negedge clk);
        valid = 1'b1; kind = k; word = w;
        @(negedge clk);
        valid = 1'b0; kind = 2'd0; word = '0;
    endtask

    task automatic idle_cycle;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 ctrl", 32'(ctrl), 0);
        check("R1 video", 32'(video), 0);
        check("R1 fix", 32'(fix), 0);
        check("R1 phase", 32'(phase), 0);
    endtask

    task automatic t_clean_ctrl;
        send(2'd1, ctrl_word(9'h1A5));
        check("R2/R3 ctrl clean", 32'(ctrl), 32'h1A5);
        check("R4 no fix on clean", 32'(fix), 0);
        check("R9 phase control", 32'(phase), 1);
        check("R6 video unchanged by ctrl", 32'(video), 0);
        send(2'd1, ctrl_word(9'h1A5) ^ 20'h1);
        check("R2 bit0 ignored", 32'(ctrl), 32'h1A5);
        check("R4 bit0 no fix", 32'(fix), 0);
    endtask

    task automatic t_single_err;
        for (int i = 1; i <= 15; i++) begin
            send(2'd1, ctrl_word(9'h0CA) ^ (20'h1 << i));
            check("R2 single flip voted", 32'(ctrl), 32'h0CA);
            check("R4 fix pulse", 32'(fix), 1);
        end
        idle_cycle();
        check("R4 fix one cycle", 32'(fix), 0);
        check("R8 ctrl held idle", 32'(ctrl), 32'h0CA);
    endtask

    task automatic t_double_err;
        // two copies of signal 1 flipped: majority follows them
        send(2'd1, ctrl_word(9'h000) ^ 20'h00030);
        check("R2 double flip", 32'(ctrl), 32'h002);
        check("R4 fix on double", 32'(fix), 1);
    endtask

    task automatic t_plain;
        send(2'd1, ctrl_word(9'h000) ^ 20'h50000);
        check("R3 plain bits", 32'(ctrl), 32'h0A0);
        check("R4 plain no fix", 32'(fix), 0);
    endtask

    task automatic t_video;
        send(2'd0, 20'hABCDE);
        check("R5 video load", 32'(video), 32'(20'hABCDE >> 2));
        check("R5 ctrl held", 32'(ctrl), 32'h0A0);
        check("R9 phase video", 32'(phase), 2);
        check("R4 no fix on video", 32'(fix), 0);
    endtask

    task automatic t_transition;
        send(2'd2, 20'h5A5A5);
        check("R7 ctrl held", 32'(ctrl), 32'h0A0);
        check("R7 video held", 32'(video), 32'(20'hABCDE >> 2));
        check("R9 phase trans", 32'(phase), 3);
        send(2'd0, 20'h12345);
        send(2'd3, 20'hFFFFF);
        check("R7 rsvd ctrl held", 32'(ctrl), 32'h0A0);
        check("R7 rsvd video held", 32'(video), 32'(20'h12345 >> 2));
        check("R9 rsvd phase", 32'(phase), 3);
    endtask

    task automatic t_ctrl_keeps_video;
        send(2'd1, ctrl_word(9'h155));
        check("R6 video held by ctrl", 32'(video), 32'(20'h12345 >> 2));
        check("R2 new ctrl", 32'(ctrl), 32'h155);
    endtask

    task automatic t_invalid;
        @(negedge clk);
        valid = 1'b0; kind = 2'd1; word = ctrl_word(9'h0AA) ^ 20'h2;
        @(negedge clk);
        check("R8 ctrl unchanged", 32'(ctrl), 32'h155);
        check("R8 fix low", 32'(fix), 0);
        check("R8 phase held", 32'(phase), 1);
        kind = 2'd0; word = 20'hFFFFF;
        @(negedge clk);
        check("R8 video unchanged", 32'(video), 32'(20'h12345 >> 2));
        word = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_ctrl();
        t_single_err();
        t_double_err();
        t_plain();
        t_video();
        t_transition();
        t_ctrl_keeps_video();
        t_invalid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule